// File: doc/BRIEF.md
# Parallel Delimiter Field-Start Scanner

This block locates the first character of every field in a byte string that is split on one programmable delimiter byte. The string arrives as blocks of N byte lanes, one block per cycle. Every lane compares its byte with the delimiter in parallel. A lane that holds a delimiter reports the position just after itself as a field start, but only when the byte to its right is not also a delimiter. As a result, a run of delimiters collapses into a single field start without any sequential scan.

The highest lane of a block takes its right-hand neighbour from a one-byte lookahead input, which carries the first byte of the following block. Lookahead positions at or beyond the string length count as non-matching. The position of the first character of a non-empty string is always a field start.

Each block yields a flag vector. A priority encoder drains the flag vector, one absolute offset per cycle, onto a valid/ready output stream. Intake of the next block is held off until the current vector is empty. When the last offset has been taken, a one-cycle done pulse is raised together with the number of fields found.

Top module: `fs_field_scan`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `done` are all 0.
- R2: For a string with length greater than 0, offset 0 is emitted first, whatever byte is at position 0.
- R3: Offset p+1 is emitted when byte p equals the delimiter, byte p+1 does not, and p+1 is less than the length. Offsets are byte positions counted from 0. The comparison covers all 8 bits.
- R4: The right neighbour of lane N-1 is `in_peek`, which is the byte at position base+N. A delimiter run that crosses a block boundary therefore yields only the start after its last delimiter. `in_peek` never matches when base+N is at or beyond the length.
- R5: A run of trailing delimiters yields no offset at or beyond the string length.
- R6: A lane whose `in_mask` bit is 0, or whose position is at or beyond the length, never matches. Lane k carries byte base+k in `in_data[8k+7:8k]`.
- R7: Offsets leave in strictly ascending order. While `out_valid` is high and `out_ready` is low, `out_offset` holds steady.
- R8: `in_ready` is 0 while any flag of the current block is still pending.
- R9: The cycle after the last offset is accepted, `done` pulses for one cycle and `field_count` equals the number of offsets. An empty string produces no offset, and its done pulse reports a count of 0.
- R10: `cfg_load` writes `cfg_delim` into the delimiter register only when no scan is running. A load during a scan is ignored, both for that scan and for later scans.
- R11: `blk_flags` holds the flag vector of the most recently accepted block. Bit 0 is the first-character flag, set only for the block at offset 0. Bit k+1 is the write flag of lane k and stands for offset base+k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load delimiter (honoured only when idle) |
| cfg_delim | input | 8 | Delimiter byte to load |
| start | input | 1 | Begin a scan (honoured only when idle) |
| str_len | input | LW | String length in bytes, sampled with start |
| in_valid | input | 1 | Block present |
| in_ready | output | 1 | Block accepted at this edge if valid |
| in_data | input | 8*N | N byte lanes, lane 0 lowest |
| in_mask | input | N | Per-lane byte-valid mask |
| in_peek | input | 8 | First byte of the following block |
| out_valid | output | 1 | Offset present |
| out_ready | input | 1 | Consumer takes the offset |
| out_offset | output | LW | Absolute field-start offset |
| blk_flags | output | N+1 | Flag vector of the last accepted block |
| done | output | 1 | One-cycle end-of-scan pulse |
| field_count | output | LW | Number of fields found |
| busy | output | 1 | Scan in progress |

## Verification
When a block is accepted at a clock edge, its flags, its first `out_valid` and its `blk_flags` all appear right after that edge. Each later offset follows one edge after the previous one is accepted. `done` arrives one edge after the edge that consumes the last offset, or one edge after start for an empty string. The bench drives inputs and reads outputs at falling edges, so every handshake it counts is the one the next rising edge performs. It judges the held-offset rule one falling edge after a refused offset. The sweep covers every two-symbol string up to nine bytes long on a four-lane instance, with the consumer both always ready and stalling. Dedicated strings cover the boundary-crossing run, the mask, a distinct byte in each bit position, and a delimiter load during a scan.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef logic [7:0] byte_t;

  // Bitwise XNOR, then two levels of AND: nibbles first, then the pair.
  function automatic logic byte_hit(input byte_t c, input byte_t d);
    byte_t eq;
    logic lo, hi;
    eq = ~(c ^ d);
    lo = &eq[3:0];
    hi = &eq[7:4];
    return lo & hi;
  endfunction
endpackage

// File: rtl/fs_lane_cmp.sv
module fs_lane_cmp #(
  parameter int N = 32
) (
  input  logic [8*N-1:0]    data,
  input  fs_pkg::byte_t     peek,
  input  fs_pkg::byte_t     delim,
  output logic [N-1:0]      raw_hit,
  output logic              peek_hit
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    assign raw_hit[k] = fs_pkg::byte_hit(data[8*k +: 8], delim);
  end
  assign peek_hit = fs_pkg::byte_hit(peek, delim);
endmodule

// File: rtl/fs_drain.sv
module fs_drain #(
  parameter int W  = 33,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  rest
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end
  assign any  = |pend;
  assign rest = pend & (pend - W'(1));
endmodule

// File: rtl/fs_field_scan.sv
module fs_field_scan #(
  parameter int N  = 32,
  parameter int LW = 16,
  localparam int FW = N + 1,
  localparam int IW = $clog2(FW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [7:0]       cfg_delim,
  input  logic             start,
  input  logic [LW-1:0]    str_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [8*N-1:0]   in_data,
  input  logic [N-1:0]     in_mask,
  input  logic [7:0]       in_peek,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LW-1:0]    out_offset,
  output logic [FW-1:0]    blk_flags,
  output logic             done,
  output logic [LW-1:0]    field_count,
  output logic             busy
);
  // position base+k lies inside the string of length l
  function automatic logic in_str(input logic [LW-1:0] b, input int unsigned k,
                                  input logic [LW-1:0] l);
    logic [LW:0] p;
    p = {1'b0, b} + (LW+1)'(k);
    return p < {1'b0, l};
  endfunction

  logic [7:0]    delim_q;
  logic [LW-1:0] len_q, base_q, blk_base, cnt_q;
  logic [FW-1:0] pend_q, flags_q;
  logic          busy_q, done_q;

  logic [N-1:0]  raw_hit, live, hit, nbr, lane_we;
  logic          peek_raw, peek_hit;
  logic [FW-1:0] new_flags, rest;
  logic [IW-1:0] idx;
  logic          any_pend, more_in, accept, pop, finish;

  fs_lane_cmp #(.N(N)) u_cmp (
    .data(in_data), .peek(in_peek), .delim(delim_q),
    .raw_hit(raw_hit), .peek_hit(peek_raw)
  );

  for (genvar k = 0; k < N; k++) begin : g_rule
    assign live[k] = in_mask[k] & in_str(base_q, k, len_q);
    assign hit[k]  = raw_hit[k] & live[k];
    if (k == N - 1) begin : g_top
      assign nbr[k] = peek_hit;
    end else begin : g_mid
      assign nbr[k] = hit[k+1];
    end
    assign lane_we[k] = hit[k] & ~nbr[k] & in_str(base_q, k + 1, len_q);
  end

  assign peek_hit  = peek_raw & in_str(base_q, N, len_q);
  assign new_flags = {lane_we, (base_q == '0)};

  fs_drain #(.W(FW)) u_drain (
    .pend(pend_q), .any(any_pend), .idx(idx), .rest(rest)
  );

  assign more_in    = in_str(base_q, 0, len_q);
  assign in_ready   = busy_q & ~any_pend & more_in;
  assign accept     = in_valid & in_ready;
  assign out_valid  = any_pend;
  assign out_offset = blk_base + LW'(idx);
  assign pop        = out_valid & out_ready;
  assign finish     = busy_q & ~any_pend & ~more_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delim_q  <= '0;
      len_q    <= '0;
      base_q   <= '0;
      blk_base <= '0;
      cnt_q    <= '0;
      pend_q   <= '0;
      flags_q  <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cfg_load) delim_q <= cfg_delim;
        if (start) begin
          busy_q <= 1'b1;
          len_q  <= str_len;
          base_q <= '0;
          cnt_q  <= '0;
          pend_q <= '0;
        end
      end else begin
        if (accept) begin
          pend_q   <= new_flags;
          flags_q  <= new_flags;
          blk_base <= base_q;
          base_q   <= base_q + LW'(N);
        end else if (pop) begin
          pend_q <= rest;
          cnt_q  <= cnt_q + LW'(1);
        end
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign blk_flags   = flags_q;
  assign done        = done_q;
  assign field_count = cnt_q;
  assign busy        = busy_q;
endmodule

// File: rtl/fs_field_scan_chk.sv
module fs_field_scan_chk #(
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [LW-1:0] out_offset,
  input logic          in_ready,
  input logic          done,
  input logic [LW-1:0] len_q
);
  logic          have_prev;
  logic [LW-1:0] prev_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_off  <= '0;
    end else if (done) begin
      have_prev <= 1'b0;
    end else if (out_valid && out_ready) begin
      have_prev <= 1'b1;
      prev_off  <= out_offset;
    end
  end

  AST_OUT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && have_prev) |-> (out_offset > prev_off)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset))); // R7
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R8
  AST_OUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_offset < len_q)); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !in_ready)); // R9
endmodule

bind fs_field_scan fs_field_scan_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_offset(out_offset), .in_ready(in_ready), .done(done), .len_q(len_q)
);

// File: tb/fs_field_scan_test.sv
module fs_field_scan_test;
  localparam int N  = 4;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [7:0] cfg_delim = '0;
  logic start = 1'b0;
  logic [LW-1:0] str_len = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [8*N-1:0] in_data = '0;
  logic [N-1:0] in_mask = '0;
  logic [7:0] in_peek = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [LW-1:0] out_offset;
  logic [N:0] blk_flags;
  logic done;
  logic [LW-1:0] field_count;
  logic busy;

  fs_field_scan #(.N(N), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_delim(cfg_delim),
    .start(start), .str_len(str_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mask(in_mask), .in_peek(in_peek),
    .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset),
    .blk_flags(blk_flags), .done(done), .field_count(field_count), .busy(busy)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int wd = 0;
  logic [7:0] str [0:15];
  logic [7:0] exp_delim;
  logic [N:0] first_flags;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit is_d(input int p, input int len, input logic [N-1:0] kill0);
    if (p >= len) return 1'b0;
    if (p < N && kill0[p]) return 1'b0;
    return str[p] == exp_delim;
  endfunction

  task automatic load_delim(input logic [7:0] d);
    @(negedge clk);
    cfg_load = 1'b1; cfg_delim = d;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic run_str(input int len, input logic [N-1:0] kill0, input bit slow,
                         input bit poke, input string tag);
    int exp_q [0:15];
    int exp_n, got, blk, cyc;
    bit fin, hold_pend, grab;
    int hold_off;
    exp_n = 0;
    if (len > 0) begin exp_q[0] = 0; exp_n = 1; end
    for (int i = 0; i < len; i++) begin
      if (is_d(i, len, kill0) && !is_d(i + 1, len, kill0) && (i + 1 < len)) begin
        exp_q[exp_n] = i + 1; exp_n++;
      end
    end
    @(negedge clk);
    start = 1'b1; str_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    got = 0; blk = 0; cyc = 0; fin = 0; hold_pend = 0; grab = 0; hold_off = 0;
    while (!fin && cyc < 300) begin
      if (grab) begin first_flags = blk_flags; grab = 0; end
      if (hold_pend) begin
        chk(out_valid && out_offset == LW'(hold_off), "R7 held offset", int'(out_offset), hold_off);
        hold_pend = 0;
      end
      if (done) begin
        fin = 1;
        chk(int'(field_count) == exp_n, "R9 field count", int'(field_count), exp_n);
        chk(got == exp_n, "R9 offsets before done", got, exp_n);
      end else begin
        out_ready = slow ? ((cyc % 3) != 1) : 1'b1;
        cfg_load = poke; cfg_delim = 8'h61;
        if (blk * N < len) begin
          in_valid = 1'b1;
          for (int k = 0; k < N; k++) begin
            int p = blk * N + k;
            in_data[8*k +: 8] = str[p];
            in_mask[k] = (p < len) && !(blk == 0 && kill0[k]);
          end
          in_peek = str[(blk + 1) * N];
        end else begin
          in_valid = 1'b0;
        end
        if (out_valid) chk(!in_ready, "R8 intake stalled", int'(in_ready), 0);
        if (in_valid && in_ready) begin
          blk++;
          if (blk == 1) grab = 1;
        end
        if (out_valid && out_ready) begin
          if (got < exp_n)
            chk(out_offset == LW'(exp_q[got]), (exp_q[got] == 0) ? "R2 first offset" : tag,
                int'(out_offset), exp_q[got]);
          else
            chk(1'b0, "R5 extra offset", int'(out_offset), -1);
          got++;
        end else if (out_valid) begin
          hold_pend = 1; hold_off = int'(out_offset);
        end
        @(negedge clk);
        cyc++;
      end
    end
    in_valid = 1'b0; out_ready = 1'b0; cfg_load = 1'b0;
    if (!fin) chk(1'b0, "R9 done timeout", cyc, 300);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) str[i] = 8'h3B;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(!in_ready, "R1 in_ready", int'(in_ready), 0);
    chk(!done, "R1 done", int'(done), 0);

    // exhaustive two-symbol sweep, lengths 0..9
    exp_delim = 8'h3B;
    load_delim(8'h3B);
    for (int len = 0; len <= 9; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        for (int i = 0; i < 16; i++) str[i] = 8'h3B;
        for (int i = 0; i < len; i++) str[i] = pat[i] ? 8'h3B : 8'h61;
        run_str(len, '0, pat[0], 1'b0, "R3 offset");
      end
    end

    // R4: run crossing block boundary "aaa;;aaa"
    for (int i = 0; i < 16; i++) str[i] = 8'h61;
    str[3] = 8'h3B; str[4] = 8'h3B;
    run_str(8, '0, 1'b0, 1'b0, "R4 boundary run");

    // R5: trailing run "a;;"
    for (int i = 0; i < 16; i++) str[i] = 8'h3B;
    str[0] = 8'h61;
    run_str(3, '0, 1'b1, 1'b0, "R5 trailing run");

    // R6: masked lane 1 in "x;xx" gives only offset 0
    for (int i = 0; i < 16; i++) str[i] = 8'h61;
    str[1] = 8'h3B;
    run_str(4, 4'b0010, 1'b0, 1'b0, "R6 masked lane");

    // R11: "DxDD" + "xxxx" -> flags 5'b10011
    for (int i = 0; i < 16; i++) str[i] = 8'h61;
    str[0] = 8'h3B; str[2] = 8'h3B; str[3] = 8'h3B;
    run_str(8, '0, 1'b0, 1'b0, "R3 offset");
    chk(first_flags == 5'b10011, "R11 block flags", int'(first_flags), 19);

    // R10: load attempt during scan is ignored now and later
    for (int i = 0; i < 16; i++) str[i] = 8'h61;
    str[1] = 8'h3B;
    run_str(4, '0, 1'b0, 1'b1, "R10 load ignored");
    run_str(4, '0, 1'b0, 1'b0, "R10 delimiter kept");

    // R3: all-bit compare, delimiter 0x00 vs single-bit bytes
    exp_delim = 8'h00;
    load_delim(8'h00);
    for (int pat = 0; pat < 256; pat++) begin
      for (int i = 0; i < 16; i++) str[i] = 8'h00;
      for (int i = 0; i < 8; i++) str[i] = pat[i] ? 8'h00 : (8'h01 << i);
      run_str(8, '0, 1'b0, 1'b0, "R3 bit compare");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule